// File: doc/BRIEF.md
# Serializer Load-Enable Timing Generator

This block runs on the fast bit-rate clock of a serializer or deserializer and produces the two framing signals such a lane needs for a word width J of 2 to 10 bits. It divides each frame of J fast cycles into slots 0 to J−1. It raises a one-cycle load strobe in slot J−2, and it drives a divided word-rate clock that rises at slot 0 and stays high for roughly half the frame.

Both outputs come straight from flip-flops, so the word clock is free of glitches and can feed the word-side logic. The width J is read at run time and clamped to the legal range. It is taken only when a new frame begins, so changing it while running never produces a shortened frame. The word clock in a real lane leads the frame origin by half a fast cycle (180/J degrees of the word period). A single-edge fast-clock design cannot express that offset, so here the word clock's rising edge coincides with slot 0.

Top module: `lenTimingGen`

## Requirements
- R1: `loadEn` is high for exactly one fast cycle per frame and never in two consecutive cycles. While running with a fixed J, it shows J−1 low cycles between pulses.
- R2: The `loadEn` pulse falls in slot J−2 of the frame, where slot 0 is the first cycle in which `wordClk` is high. For J = 2 this means `loadEn` and `wordClk` are high together in slot 0.
- R3: `wordClk` has a period of J fast cycles. It is high in slots 0 through ceil(J/2)−1 and low in the remaining slots, so for odd J it is high one cycle longer than it is low.
- R4: A new value on `factor` is taken only when the frame wraps from slot J−1 to slot 0, or on a start. The frame in progress completes with the old J, so the next `loadEn` follows the last old-frame pulse after exactly the new J cycles.
- R5: While `rst` is high at a clock edge, both outputs are low after that edge and the frame position returns to slot 0. The first clock edge that samples `rst` low and `runEn` high starts a frame, and the cycle after that edge is slot 0.
- R6: A clock edge that samples `runEn` low drives both outputs low from the next cycle on, and they stay low whatever `factor` does. Raising `runEn` again restarts at slot 0 with the current `factor`.
- R7: `factor` is an unsigned binary count. Values below 2 behave as J = 2, and values above 10 behave as J = 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Run enable; low holds the generator idle |
| factor | input | FACTOR_W (4) | Requested word width J, unsigned |
| loadEn | output | 1 | One-cycle load strobe in slot J−2 |
| wordClk | output | 1 | Registered word-rate clock, rising at slot 0 |

## Verification
The bench builds the block with its default parameters: J from 2 to 10 and a 4-bit `factor` port. With these values every code from 0 to 15 can be applied, so clamping is exercised on both sides of the legal range. Both the even and odd duty patterns are covered, along with the degenerate J = 2 case where the strobe and the clock's high phase coincide. A width change is issued in the middle of a frame, and the run enable is dropped partway through a frame.

// File: rtl/lenGenPkg.sv
package lenGenPkg;

  // One-hot command from the sequencing control to the slot datapath.
  typedef struct packed {
    logic hold;     // park at slot 0 with outputs low
    logic restart;  // begin a fresh frame at slot 0
    logic advance;  // move to the next slot, wrapping after slot J-1
  } lenStrobe_t;

endpackage

// File: rtl/lenFactorClamp.sv
module lenFactorClamp #(
  parameter int MIN_J = 2,
  parameter int MAX_J = 10,
  parameter int JW    = 4
) (
  input  logic [JW-1:0] rawJ,
  output logic [JW-1:0] legalJ
);

  localparam logic [JW-1:0] LO = JW'(MIN_J);
  localparam logic [JW-1:0] HI = JW'(MAX_J);

  always_comb begin
    if (rawJ < LO)      legalJ = LO;
    else if (rawJ > HI) legalJ = HI;
    else                legalJ = rawJ;
  end

endmodule

// File: rtl/lenCtrl.sv
module lenCtrl
  import lenGenPkg::*;
#(
  parameter int MIN_J = 2,
  parameter int JW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          runEn,
  input  logic [JW-1:0] legalJ,
  input  logic          lastSlot,
  output lenStrobe_t    strobe,
  output logic [JW-1:0] curJ,
  output logic [JW-1:0] nextJ,
  output logic          active
);

  logic takeNew;

  // Pick the one command for this cycle.
  always_comb begin
    strobe = '0;
    if (rst || !runEn)  strobe.hold    = 1'b1;
    else if (!active)   strobe.restart = 1'b1;
    else                strobe.advance = 1'b1;
  end

  // A new width is only accepted on a start or at a frame wrap.
  assign takeNew = strobe.restart || (strobe.advance && lastSlot);
  assign nextJ   = takeNew ? legalJ : curJ;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      curJ   <= JW'(MIN_J);
    end else begin
      active <= !strobe.hold;
      curJ   <= nextJ;
    end
  end

endmodule

// File: rtl/lenPath.sv
module lenPath
  import lenGenPkg::*;
#(
  parameter int JW = 4,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  lenStrobe_t    strobe,
  input  logic [JW-1:0] curJ,
  input  logic [JW-1:0] nextJ,
  output logic [SW-1:0] slot,
  output logic          lastSlot,
  output logic          loadEn,
  output logic          wordClk
);

  logic [SW-1:0] nextSlot;
  logic          nextRun;
  logic [JW:0]   highLen;
  logic          loadD;
  logic          clkD;

  assign lastSlot = (JW'(slot) == curJ - JW'(1));

  always_comb begin
    if (strobe.hold || strobe.restart) nextSlot = '0;
    else if (lastSlot)                 nextSlot = '0;
    else                               nextSlot = slot + SW'(1);
  end

  assign nextRun = !strobe.hold;

  // Outputs are decoded from the next-state slot and width, so the
  // registered outputs line up with the slot register in every cycle.
  assign highLen = ({1'b0, nextJ} + (JW+1)'(1)) >> 1;
  assign loadD   = nextRun && (JW'(nextSlot) == nextJ - JW'(2));
  assign clkD    = nextRun && ((JW+1)'(nextSlot) < highLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      loadEn  <= 1'b0;
      wordClk <= 1'b0;
    end else begin
      slot    <= nextSlot;
      loadEn  <= loadD;
      wordClk <= clkD;
    end
  end

endmodule

// File: rtl/lenTimingGen.sv
module lenTimingGen
  import lenGenPkg::*;
#(
  parameter int MIN_J    = 2,
  parameter int MAX_J    = 10,
  parameter int FACTOR_W = $clog2(MAX_J + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                runEn,
  input  logic [FACTOR_W-1:0] factor,
  output logic                loadEn,
  output logic                wordClk
);

  localparam int SLOT_W = $clog2(MAX_J);

  lenStrobe_t          strobe;
  logic [FACTOR_W-1:0] legalJ;
  logic [FACTOR_W-1:0] curJ;
  logic [FACTOR_W-1:0] nextJ;
  logic [SLOT_W-1:0]   slotQ;
  logic                lastSlot;
  logic                active;

  lenFactorClamp #(.MIN_J(MIN_J), .MAX_J(MAX_J), .JW(FACTOR_W)) i_clamp (
    .rawJ   (factor),
    .legalJ (legalJ)
  );

  lenCtrl #(.MIN_J(MIN_J), .JW(FACTOR_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .runEn    (runEn),
    .legalJ   (legalJ),
    .lastSlot (lastSlot),
    .strobe   (strobe),
    .curJ     (curJ),
    .nextJ    (nextJ),
    .active   (active)
  );

  lenPath #(.JW(FACTOR_W), .SW(SLOT_W)) i_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curJ     (curJ),
    .nextJ    (nextJ),
    .slot     (slotQ),
    .lastSlot (lastSlot),
    .loadEn   (loadEn),
    .wordClk  (wordClk)
  );

endmodule

// File: rtl/lenTimingGenChk.sv
module lenTimingGenChk #(
  parameter int MIN_J = 2,
  parameter int MAX_J = 10,
  parameter int JW    = 4,
  parameter int SW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          runEn,
  input logic          loadEn,
  input logic          wordClk,
  input logic [SW-1:0] slot,
  input logic [JW-1:0] curJ,
  input logic          active
);

  a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> !loadEn);

  a_r2_slot_position: assert property (@(posedge clk) disable iff (rst)
    loadEn |-> (JW'(slot) == curJ - JW'(2)));

  a_r3_rise_at_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(wordClk) |-> (slot == '0));

  a_r3_high_at_origin: assert property (@(posedge clk) disable iff (rst)
    (active && slot == '0) |-> wordClk);

  a_r4_width_held: assert property (@(posedge clk) disable iff (rst)
    (slot != '0) |-> $stable(curJ));

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !$past(runEn) |-> (!loadEn && !wordClk));

  a_r7_width_legal: assert property (@(posedge clk) disable iff (rst)
    active |-> (curJ >= JW'(MIN_J) && curJ <= JW'(MAX_J)));

endmodule

bind lenTimingGen lenTimingGenChk #(
  .MIN_J (MIN_J),
  .MAX_J (MAX_J),
  .JW    (FACTOR_W),
  .SW    (SLOT_W)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .runEn   (runEn),
  .loadEn  (loadEn),
  .wordClk (wordClk),
  .slot    (slotQ),
  .curJ    (curJ),
  .active  (active)
);

// File: tb/test_lenTimingGen.sv
module test_lenTimingGen;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_J = 2;
  localparam int MAX_J = 10;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          runEn = 1'b0;
  logic [FW-1:0] factor = 4'd4;
  logic          loadEn;
  logic          wordClk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference state, from the requirements
  bit mAct = 1'b0;
  int mSlot = 0;
  int mJ = MIN_J;

  int leCount = 0;
  int wcHigh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lenTimingGen i_lenTimingGen (
    .clk     (clk),
    .rst     (rst),
    .runEn   (runEn),
    .factor  (factor),
    .loadEn  (loadEn),
    .wordClk (wordClk)
  );

  function automatic int clampJ(int v);
    if (v < MIN_J) return MIN_J;
    if (v > MAX_J) return MAX_J;
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock edge; model update; compare outputs after the edge.
  task automatic step(string tag);
    @(posedge clk);
    if (rst || !runEn) begin
      mAct = 1'b0; mSlot = 0;
    end else if (!mAct) begin
      mAct = 1'b1; mSlot = 0; mJ = clampJ(int'(factor));
    end else if (mSlot == mJ - 1) begin
      mSlot = 0; mJ = clampJ(int'(factor));
    end else begin
      mSlot++;
    end
    #1;
    check(tag, "loadEn", int'(loadEn), int'(mAct && mSlot == mJ - 2));
    check(tag, "wordClk", int'(wordClk), int'(mAct && mSlot < (mJ + 1) / 2));
    if (loadEn) leCount++;
    if (wordClk) wcHigh++;
  endtask

  task automatic restart(int j);
    runEn = 1'b0;
    step("R6");
    factor = FW'(j);
    runEn = 1'b1;
    leCount = 0;
    wcHigh = 0;
  endtask

  task automatic testReset();
    rst = 1'b1; runEn = 1'b1; factor = 4'd4;
    for (int i = 0; i < 3; i++) step("R5");
    check("R5", "loadEn in reset", int'(loadEn), 0);
    check("R5", "wordClk in reset", int'(wordClk), 0);
    rst = 1'b0;
    step("R5");
    check("R5", "wordClk at first slot", int'(wordClk), 1);
  endtask

  task automatic testEvenWidth();
    restart(4);
    for (int i = 0; i < 12; i++) step("R2");
    check("R1", "pulses in 3 frames J=4", leCount, 3);
    check("R3", "high cycles in 3 frames J=4", wcHigh, 6);
  endtask

  task automatic testOddWidth();
    restart(5);
    for (int i = 0; i < 10; i++) step("R3");
    check("R3", "high cycles in 2 frames J=5", wcHigh, 6);
    check("R1", "pulses in 2 frames J=5", leCount, 2);
  endtask

  task automatic testExtremes();
    restart(2);
    for (int i = 0; i < 8; i++) step("R2");
    check("R2", "pulses in 4 frames J=2", leCount, 4);
    check("R3", "high cycles in 4 frames J=2", wcHigh, 4);
    restart(10);
    for (int i = 0; i < 20; i++) step("R1");
    check("R1", "pulses in 2 frames J=10", leCount, 2);
    check("R3", "high cycles in 2 frames J=10", wcHigh, 10);
  endtask

  task automatic testWidthChange();
    int gap;
    restart(4);
    step("R4");
    step("R4");
    factor = 4'd7;
    step("R4");
    check("R4", "old-frame pulse at slot 2", int'(loadEn), 1);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      step("R4");
      gap++;
      if (loadEn) break;
    end
    check("R4", "cycles to next pulse", gap, 7);
  endtask

  task automatic testClamp();
    restart(0);
    for (int i = 0; i < 8; i++) step("R7");
    check("R7", "pulses with factor 0", leCount, 4);
    restart(1);
    for (int i = 0; i < 6; i++) step("R7");
    check("R7", "pulses with factor 1", leCount, 3);
    restart(15);
    for (int i = 0; i < 20; i++) step("R7");
    check("R7", "pulses with factor 15", leCount, 2);
    check("R7", "high cycles with factor 15", wcHigh, 10);
  endtask

  task automatic testStop();
    restart(6);
    for (int i = 0; i < 3; i++) step("R6");
    runEn = 1'b0;
    leCount = 0; wcHigh = 0;
    for (int i = 0; i < 5; i++) begin
      factor = FW'(i + 2);
      step("R6");
    end
    check("R6", "pulses while stopped", leCount, 0);
    check("R6", "high cycles while stopped", wcHigh, 0);
    factor = 4'd3;
    runEn = 1'b1;
    step("R6");
    check("R6", "wordClk on restart", int'(wordClk), 1);
  endtask

  task automatic testResetMidRun();
    restart(8);
    for (int i = 0; i < 5; i++) step("R5");
    rst = 1'b1;
    step("R5");
    check("R5", "wordClk after mid-run reset", int'(wordClk), 0);
    rst = 1'b0;
    step("R5");
    check("R5", "wordClk at slot 0 after reset", int'(wordClk), 1);
    for (int i = 0; i < 16; i++) step("R5");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    testReset();
    testEvenWidth();
    testOddWidth();
    testExtremes();
    testWidthChange();
    testClamp();
    testStop();
    testResetMidRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule